// File: doc/BRIEF.md
# Command-Parity SPI Slave Frame Port

This block terminates a 16-clock SPI frame on the slave side of a register-mapped peripheral. On the serial input it receives one command byte and then one data byte. The command byte holds a 7-bit command and one odd-parity bit. The most significant command bit selects a write, and the six bits below it address one of 64 registers. While that frame comes in, the block drives a status byte and then the contents of the addressed register on the serial output.

A write reaches the register port only when two conditions hold: the frame was exactly 16 bits long, and the command byte had odd parity. The data byte has no protection. Every bit the block drives on the serial output is also read back from the line and compared with what was intended. Both kinds of fault, a bad command and a readback disagreement, are held as flags and reported in the status byte of the following frame. The block oversamples the serial pins on its own system clock.

Top module: `spi_cmdpar_slave`

## Requirements
- R1: A frame is taken MSB first on rising SCLK edges while cs_n is low. The bit order is command bits c6..c0, then the parity bit, then data bits d7..d0. c6 set means write, and c5..c0 is the register address.
- R2: A write executes only if the 8-bit command byte (c6..c0 plus the parity bit) holds an odd number of ones. With even parity the register port stays idle.
- R3: The data byte carries no parity. Any data value, of either parity, is written unchanged when the command is valid.
- R4: When cs_n rises after any number of rising edges other than 16, the frame's write is suppressed and a command error is recorded.
- R5: MISO presents the status byte and then the read-data byte, MSB first. The first bit is valid after cs_n falls and before the first rising edge, and each later bit changes only after a falling SCLK edge.
- R6: The read-data byte equals the addressed register as it stood before this frame's own write.
- R7: Status bit 0 is set when the previous frame had a command error (wrong parity or wrong length).
- R8: Status bit 2 is set when, in the previous frame, the level read back on miso_fb at some rising SCLK edge differed from the level being driven. All other status bits read 0.
- R9: Both flags clear once they have been shifted out. A frame that follows an error-free frame reports status 0x00.
- R10: After cs_n rises on a valid write frame, reg_we pulses for exactly one clock, carrying the address and the data byte.
- R11: After reset, miso is 0, reg_we is 0, and the first frame reports status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| mosi | input | 1 | Serial command and data from the master |
| miso | output | 1 | Serial status and read data to the master |
| miso_fb | input | 1 | Level sensed back from the serial output line |
| reg_we | output | 1 | One-clock write strobe to the register file |
| reg_addr | output | 6 | Register address taken from the command |
| reg_wdata | output | 8 | Data byte to be written |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
Two events can land on the same system clock. One is the readback comparison on the sixteenth rising edge. The other is the end-of-frame decision, which happens when chip select is released together with that edge. The bench provokes this by raising cs_n at the same instant as the sixteenth SCLK rise. In that frame the parity is bad and a forced readback error sits on the last bit. The bench then expects no write, a next status of 0x05 carrying both flags, and a status of 0x00 in the frame after that.

// File: rtl/spi_cmdpar_pkg.sv
package spi_cmdpar_pkg;

   typedef struct packed {
      logic cmd_err;
      logic sdo_err;
   } err_flags_t;

   function automatic int cnt_width(input int frame_bits);
      return $clog2(frame_bits + 2);
   endfunction

endpackage

// File: rtl/spi_cmdpar_sync.sv
module spi_cmdpar_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= RST_VAL;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[s] <= RST_VAL;
            else        st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_cmdpar_rx.sv
module spi_cmdpar_rx
   import spi_cmdpar_pkg::*;
#(
   parameter int CMD_W      = 7,
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1,
   localparam int CMDB_W    = CMD_W + 1,
   localparam int ADDR_W    = CMD_W - 1,
   localparam int FRAME_W   = CMDB_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rise,
   input  logic              mosi_i,
   output logic              cmd_done,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_flag,
   output logic [DATA_W-1:0] data,
   output logic              frame_ok
);
   localparam int CNT_W = cnt_width(FRAME_W);

   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;
   logic [CMDB_W-1:0]  cmd_f;
   logic               par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         shreg    <= '0;
         cmd_done <= 1'b0;
      end else begin
         cmd_done <= rise && (cnt == CNT_W'(CMDB_W - 1));
         if (start) begin
            cnt   <= '0;
            shreg <= '0;
         end else if (rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_i};
            if (cnt != '1) cnt <= cnt + 1'b1;
         end
      end
   end

   assign cmd_addr = shreg[ADDR_W:1];
   assign cmd_f    = shreg[FRAME_W-1 -: CMDB_W];
   assign wr_flag  = shreg[FRAME_W-1];
   assign data     = shreg[DATA_W-1:0];

   if (ODD_PARITY) begin : g_odd
      assign par_ok = ^cmd_f;
   end else begin : g_even
      assign par_ok = ~^cmd_f;
   end

   assign frame_ok = (cnt == CNT_W'(FRAME_W)) && par_ok;

   // R1
   cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> cnt >= $past(cnt));
endmodule

// File: rtl/spi_cmdpar_tx.sv
module spi_cmdpar_tx
   import spi_cmdpar_pkg::*;
#(
   parameter int STAT_W   = 8,
   parameter int DATA_W   = 8,
   localparam int FRAME_W = STAT_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fall,
   input  logic              rise,
   input  logic [STAT_W-1:0] status,
   input  logic [DATA_W-1:0] rdata,
   input  logic              fb,
   output logic              miso,
   output logic              mismatch
);
   localparam int CNT_W = cnt_width(FRAME_W);

   logic [STAT_W-1:0]  stat_q;
   logic [CNT_W-1:0]   fidx;
   logic [FRAME_W-1:0] stream;
   logic [FRAME_W-1:0] shifted;

   assign stream  = {stat_q, rdata};
   assign shifted = stream << fidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q   <= '0;
         fidx     <= '0;
         miso     <= 1'b0;
         mismatch <= 1'b0;
      end else begin
         mismatch <= rise && (fb != miso);
         if (start) begin
            stat_q <= status;
            miso   <= status[STAT_W-1];
            fidx   <= CNT_W'(1);
         end else if (fall) begin
            miso <= shifted[FRAME_W-1];
            if (fidx != '1) fidx <= fidx + 1'b1;
         end
      end
   end

   // R5
   miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !fall) |=> $stable(miso));
endmodule

// File: rtl/spi_cmdpar_slave.sv
module spi_cmdpar_slave
   import spi_cmdpar_pkg::*;
#(
   parameter int CMD_W        = 7,
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit ODD_PARITY   = 1'b1,
   parameter int STAT_CMD_BIT = 0,
   parameter int STAT_SDO_BIT = 2,
   localparam int ADDR_W      = CMD_W - 1,
   localparam int STAT_W      = CMD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   input  logic              miso_fb,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (CMD_W < 2)            begin : g_bad_cmd  $error("CMD_W must be at least 2"); end
   if (SYNC_STAGES < 2)      begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   if (STAT_CMD_BIT >= STAT_W || STAT_SDO_BIT >= STAT_W)
                             begin : g_bad_pos  $error("status bit outside status byte"); end
   if (STAT_CMD_BIT == STAT_SDO_BIT)
                             begin : g_bad_dup  $error("status bits must differ"); end

   logic sclk_s, cs_s, mosi_s, fb_s;
   logic sclk_q, csn_q, end_q, rd_pend;
   logic start, rise, fall, stop;
   logic cmd_done, wr_flag, frame_ok, mismatch;
   logic [ADDR_W-1:0] cmd_addr, addr_q;
   logic [DATA_W-1:0] rx_data, rdata_q;
   logic [STAT_W-1:0] status;
   err_flags_t        flags;

   spi_cmdpar_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sclk, cs_n, mosi, miso_fb}),
      .q({sclk_s, cs_s, mosi_s, fb_s})
   );

   assign start = csn_q & ~cs_s;
   assign stop  = ~csn_q & cs_s;
   assign rise  = sclk_s & ~sclk_q & ~csn_q;
   assign fall  = ~sclk_s & sclk_q & ~cs_s & ~csn_q;

   spi_cmdpar_rx #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(start), .rise(rise), .mosi_i(mosi_s),
      .cmd_done(cmd_done), .cmd_addr(cmd_addr), .wr_flag(wr_flag),
      .data(rx_data), .frame_ok(frame_ok)
   );

   always_comb begin
      status               = '0;
      status[STAT_CMD_BIT] = flags.cmd_err;
      status[STAT_SDO_BIT] = flags.sdo_err;
   end

   spi_cmdpar_tx #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .fall(fall), .rise(rise),
      .status(status), .rdata(rdata_q), .fb(fb_s),
      .miso(miso), .mismatch(mismatch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         csn_q     <= 1'b1;
         end_q     <= 1'b0;
         rd_pend   <= 1'b0;
         addr_q    <= '0;
         rdata_q   <= '0;
         flags     <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         sclk_q  <= sclk_s;
         csn_q   <= cs_s;
         end_q   <= stop;
         rd_pend <= cmd_done;
         reg_we  <= 1'b0;
         if (cmd_done) addr_q  <= cmd_addr;
         if (rd_pend)  rdata_q <= reg_rdata;
         if (start) flags <= '0;
         else if (mismatch) flags.sdo_err <= 1'b1;
         if (end_q) begin
            if (!frame_ok) flags.cmd_err <= 1'b1;
            else if (wr_flag) begin
               reg_we    <= 1'b1;
               reg_wdata <= rx_data;
            end
         end
      end
   end

   assign reg_addr = addr_q;

   // R10
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R10
   we_idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> cs_s);
   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (flags == '0));
   // R7
   cmd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_q && !frame_ok) |=> flags.cmd_err);
   // R8
   sdo_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatch && !start) |=> flags.sdo_err);
endmodule

// File: tb/spi_cmdpar_slave_bench.sv
module spi_cmdpar_slave_bench;
   localparam int HALF = 8;
   localparam int NV   = 10;
   localparam int NONE = 31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, inj_bit = 1'b0;
   logic miso, miso_fb, reg_we;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] rf [64];
   logic [7:0] sh [64];
   int checks = 0, fails = 0, we_cnt = 0;
   logic [5:0] we_addr;
   logic [7:0] we_data;
   logic m_cmd = 1'b0, m_sdo = 1'b0, done = 1'b0;

   always #2.5 clk = ~clk;

   spi_cmdpar_slave u_spi_cmdpar_slave (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_fb(miso_fb), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   assign miso_fb   = miso ^ inj_bit;
   assign reg_rdata = rf[reg_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) rf[i] <= 8'(i * 7 + 3);
      end else if (reg_we) begin
         rf[reg_addr] <= reg_wdata;
         we_cnt  <= we_cnt + 1;
         we_addr <= reg_addr;
         we_data <= reg_wdata;
      end
   end

   // {cmd7, bad parity, data8, injected bit index (31 none), bit count, cs with last rise}
   localparam logic [26:0] VEC [NV] = '{
      {7'h45, 1'b0, 8'hA5, 5'd31, 5'd16, 1'b0},
      {7'h05, 1'b0, 8'h00, 5'd31, 5'd16, 1'b0},
      {7'h49, 1'b1, 8'h3C, 5'd31, 5'd16, 1'b0},
      {7'h09, 1'b0, 8'h00, 5'd3,  5'd16, 1'b0},
      {7'h49, 1'b0, 8'h00, 5'd31, 5'd16, 1'b0},
      {7'h7F, 1'b0, 8'hFF, 5'd31, 5'd12, 1'b0},
      {7'h3F, 1'b0, 8'h00, 5'd31, 5'd16, 1'b0},
      {7'h42, 1'b0, 8'h81, 5'd15, 5'd17, 1'b0},
      {7'h02, 1'b0, 8'h00, 5'd31, 5'd16, 1'b0},
      {7'h09, 1'b0, 8'h00, 5'd31, 5'd16, 1'b0}
   };

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic [6:0] c, input logic badp, input logic [7:0] d,
                            input int inj, input int nb, input logic early);
      logic [15:0] tx;
      logic [15:0] got;
      logic [7:0]  est, erd;
      logic        p, bad, wr;
      int          we0;
      p   = ~(^c) ^ badp;
      tx  = {c, p, d};
      got = '0;
      est = 8'h00;
      est[0] = m_cmd;
      est[2] = m_sdo;
      m_cmd = 1'b0;
      m_sdo = 1'b0;
      erd = sh[c[5:0]];
      we0 = we_cnt;
      @(negedge clk);
      mosi    = tx[15];
      inj_bit = (inj == 0);
      cs_n    = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < nb; k++) begin
         if (k < 16) got[15-k] = miso;
         sclk = 1'b1;
         if (early && k == nb - 1) cs_n = 1'b1;
         repeat (HALF) @(negedge clk);
         if (!(early && k == nb - 1)) begin
            sclk    = 1'b0;
            inj_bit = (inj == k + 1);
            mosi    = (k + 1 < 16) ? tx[14-k] : 1'b0;
            repeat (HALF) @(negedge clk);
         end
      end
      cs_n    = 1'b1;
      sclk    = 1'b0;
      inj_bit = 1'b0;
      repeat (12) @(negedge clk);
      if (inj >= 0 && inj < nb) m_sdo = 1'b1;
      bad   = (nb != 16) || badp;
      m_cmd = bad;
      wr    = !bad && c[6];
      if (wr) sh[c[5:0]] = d;
      if (nb >= 8)
         check(got[15:8] == est, "R7/R8/R9 status byte", int'(got[15:8]), int'(est));
      if (nb == 16)
         check(got[7:0] == erd, "R5/R6 read data", int'(got[7:0]), int'(erd));
      check((we_cnt - we0) == int'(wr), "R2/R4 write count", we_cnt - we0, int'(wr));
      if (wr) begin
         check(we_addr == c[5:0], "R1/R10 write address", int'(we_addr), int'(c[5:0]));
         check(we_data == d, "R3/R10 write data", int'(we_data), int'(d));
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual 0x1 expected 0x0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) sh[i] = 8'(i * 7 + 3);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R11 reset state
      check(miso == 1'b0, "R11 miso after reset", int'(miso), 0);
      check(reg_we == 1'b0, "R11 reg_we after reset", int'(reg_we), 0);
      for (int v = 0; v < NV; v++)
         run_frame(VEC[v][26:20], VEC[v][19], VEC[v][18:11], int'(VEC[v][10:6]),
                   int'(VEC[v][5:1]), VEC[v][0]);
      // R8 R7 collision: cs released with the 16th rise, bad parity, readback error on last bit
      run_frame(7'h47, 1'b1, 8'h11, 15, 16, 1'b1);
      run_frame(7'h07, 1'b0, 8'h00, NONE, 16, 1'b0);
      // R9 flags gone after being reported
      run_frame(7'h07, 1'b0, 8'h00, NONE, 16, 1'b0);
      // R3 data byte with even parity written as is
      run_frame(7'h50, 1'b0, 8'h03, NONE, 16, 1'b0);
      run_frame(7'h10, 1'b0, 8'h00, NONE, 16, 1'b0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule